// File: doc/BRIEF.md
# LCD Vertical Frame Timing Generator

This block produces the line-by-line vertical sequence of a raster LCD controller. A single-cycle line strobe, supplied by the horizontal timing logic, marks the end of every line. The block counts these strobes through four phases in a fixed order: sync, back porch, active lines, front porch. After the front porch it returns to sync. It reports the current phase through a vertical sync output, a vertical active flag, a one-cycle frame-start pulse, and the index of the current active line.

The timing is held in one 32-bit read/write register. The back porch length sits in bits [31:24] and the front porch length in bits [23:16]. Bits [15:10] hold the sync width minus one, and bits [9:0] hold the number of active lines minus one. A mode pin selects how the sync phase behaves. For an active display, vertical sync is driven high during the sync phase. For a passive display, the sync phase becomes a run of extra blank lines, and the sync output stays low. A new register value and a new mode take effect together at the next frame boundary, so a frame in flight keeps its timing.

Top module: `lcd_vframe_gen`

## Requirements
- R1: The register reads back the last value written through `cfg_wdata` in the cycle after `cfg_we`. Its layout is back porch [31:24], front porch [23:16], sync width minus one [15:10], active lines minus one [9:0]. It resets to zero.
- R2: While reset is held, and after reset until the first strobe, the outputs show the first line of a sync phase: `vsync`=1, `vactive`=0, `line_idx`=0, `frame_start`=0.
- R3: Lines follow the order sync (width+1 lines), back porch (back lines), active (lines+1 lines), front porch (front lines), then sync again.
- R4: A porch field of zero removes that phase entirely. No line is spent on it.
- R5: In active-display mode (`passive_mode`=0), `vsync` is high on every sync-phase line and low on every other line.
- R6: In passive mode (`passive_mode`=1), `vsync` stays low. The sync phase still takes width+1 blank lines, and these come before the back porch.
- R7: `vactive` is high exactly on active lines. `line_idx` counts 0 up to the programmed line count minus one across those lines, and reads 0 on all other lines.
- R8: `frame_start` is high for exactly one clock, in the cycle after the strobe that enters the first active line.
- R9: Without a strobe, the phase, the line count and the outputs hold.
- R10: A register write and the `passive_mode` level are captured only at the strobe that enters the sync phase. The frame in progress finishes with the previous timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle strobe at the end of each line |
| passive_mode | input | 1 | 1 selects passive display (blank lines replace sync) |
| cfg_we | input | 1 | Timing register write enable |
| cfg_wdata | input | 32 | Timing register write data |
| cfg_rdata | output | 32 | Timing register read data |
| vsync | output | 1 | Vertical sync, active high |
| vactive | output | 1 | High on active lines |
| frame_start | output | 1 | One-cycle pulse at the first active line |
| line_idx | output | 10 | Index of the current active line |

## Verification
The hardest case to reach is a register update arriving while a frame is in flight. That frame must finish with its old active length and front porch. The new sync width, mode and back porch must appear only after the boundary. The stimulus writes each new setting right after a frame-start pulse, then counts the remaining lines against the previous setting and the following phases against the new one. The settings include both porches at their maximum of 255, the widest sync, the largest line count, and every switch between passive and active mode.

// File: rtl/lcd_vframe_pkg.sv
package lcd_vframe_pkg;

  localparam int VF_BP_W  = 8;
  localparam int VF_FP_W  = 8;
  localparam int VF_SW_W  = 6;
  localparam int VF_LN_W  = 10;
  localparam int VF_REG_W = VF_BP_W + VF_FP_W + VF_SW_W + VF_LN_W;

  localparam int VF_MAX_A = (VF_BP_W > VF_FP_W) ? VF_BP_W : VF_FP_W;
  localparam int VF_MAX_B = (VF_SW_W > VF_LN_W) ? VF_SW_W : VF_LN_W;
  localparam int VF_CNT_W = (VF_MAX_A > VF_MAX_B) ? VF_MAX_A : VF_MAX_B;
  localparam int VF_LEN_W = VF_CNT_W + 1;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } vf_phase_e;

  // Field order in the packed struct fixes the register bit layout.
  typedef struct packed {
    logic [VF_BP_W-1:0] back;
    logic [VF_FP_W-1:0] front;
    logic [VF_SW_W-1:0] sync_m1;
    logic [VF_LN_W-1:0] lines_m1;
  } vf_cfg_t;

  function automatic vf_cfg_t vf_unpack(input logic [VF_REG_W-1:0] word);
    return vf_cfg_t'(word);
  endfunction

  // Number of lines spent in a phase under a given setting.
  function automatic logic [VF_LEN_W-1:0] vf_phase_len(input vf_phase_e ph,
                                                       input vf_cfg_t c);
    logic [VF_LEN_W-1:0] one;
    one = VF_LEN_W'(1);
    case (ph)
      PH_SYNC: return VF_LEN_W'(c.sync_m1) + one;
      PH_BACK: return VF_LEN_W'(c.back);
      PH_ACT:  return VF_LEN_W'(c.lines_m1) + one;
      default: return VF_LEN_W'(c.front);
    endcase
  endfunction

  function automatic vf_phase_e vf_succ(input vf_phase_e ph);
    case (ph)
      PH_SYNC: return PH_BACK;
      PH_BACK: return PH_ACT;
      PH_ACT:  return PH_FRONT;
      default: return PH_SYNC;
    endcase
  endfunction

  // Successor that skips a zero-length porch; sync and active are never empty.
  function automatic vf_phase_e vf_next_live(input vf_phase_e ph, input vf_cfg_t c);
    vf_phase_e s;
    s = vf_succ(ph);
    if (vf_phase_len(s, c) == '0) s = vf_succ(s);
    return s;
  endfunction

endpackage

// File: rtl/lcd_vframe_regs.sv
module lcd_vframe_regs
  import lcd_vframe_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [VF_REG_W-1:0] cfg_wdata,
  input  logic                passive_mode,
  input  logic                load_evt,
  output logic [VF_REG_W-1:0] cfg_rdata,
  output vf_cfg_t             cfg_act,
  output logic                pas_act
);

  logic [VF_REG_W-1:0] live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (cfg_we) begin
      live_q <= cfg_wdata;
    end
  end

  // Working copy used by the sequencer; refreshed only at a frame boundary.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_act <= '0;
      pas_act <= 1'b0;
    end else if (load_evt) begin
      cfg_act <= vf_unpack(live_q);
      pas_act <= passive_mode;
    end
  end

  assign cfg_rdata = live_q;

  assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> ($stable(cfg_act) && $stable(pas_act)));

endmodule

// File: rtl/lcd_vframe_seq.sv
module lcd_vframe_seq
  import lcd_vframe_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_stb,
  input  vf_cfg_t             cfg,
  output vf_phase_e           phase,
  output logic [VF_CNT_W-1:0] cnt,
  output logic                wrap_evt,
  output logic                act_entry_evt
);

  logic [VF_LEN_W-1:0] cur_len;
  logic                at_last;
  logic                advance;
  vf_phase_e           nxt_phase;

  always_comb begin
    cur_len       = vf_phase_len(phase, cfg);
    at_last       = (VF_LEN_W'(cnt) + VF_LEN_W'(1)) >= cur_len;
    nxt_phase     = vf_next_live(phase, cfg);
    advance       = line_stb && at_last;
    wrap_evt      = advance && (nxt_phase == PH_SYNC);
    act_entry_evt = advance && (nxt_phase == PH_ACT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (line_stb) begin
      if (at_last) begin
        phase <= nxt_phase;
        cnt   <= '0;
      end else begin
        cnt   <= cnt + 1'b1;
      end
    end
  end

  assert_cnt_in_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    VF_LEN_W'(cnt) < cur_len);

  assert_hold_no_stb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> ($stable(phase) && $stable(cnt)));

endmodule

// File: rtl/lcd_vframe_gen.sv
module lcd_vframe_gen
  import lcd_vframe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_stb,
  input  logic        passive_mode,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        vsync,
  output logic        vactive,
  output logic        frame_start,
  output logic [9:0]  line_idx
);

  vf_cfg_t             cfg_act;
  logic                pas_act;
  vf_phase_e           phase;
  logic [VF_CNT_W-1:0] cnt;
  logic                wrap_evt;
  logic                act_entry_evt;
  logic                fs_q;

  lcd_vframe_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .passive_mode (passive_mode),
    .load_evt     (wrap_evt),
    .cfg_rdata    (cfg_rdata),
    .cfg_act      (cfg_act),
    .pas_act      (pas_act)
  );

  lcd_vframe_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_stb      (line_stb),
    .cfg           (cfg_act),
    .phase         (phase),
    .cnt           (cnt),
    .wrap_evt      (wrap_evt),
    .act_entry_evt (act_entry_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) fs_q <= 1'b0;
    else        fs_q <= act_entry_evt;
  end

  assign vsync       = (phase == PH_SYNC) && !pas_act;
  assign vactive     = (phase == PH_ACT);
  assign line_idx    = vactive ? cnt[VF_LN_W-1:0] : '0;
  assign frame_start = fs_q;

  assert_fs_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  assert_fs_at_first_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (vactive && line_idx == '0));

  assert_idx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vactive |-> (line_idx <= cfg_act.lines_m1));

  assert_vsync_on_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> $past(line_stb));

endmodule

// File: tb/tb_lcd_vframe_gen.sv
module tb_lcd_vframe_gen;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {passive, bp[31:24] fp[23:16] sw-1[15:10] lines-1[9:0]}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 32'h0203_0404},
    {1'b0, 32'h0000_0000},
    {1'b1, 32'h0102_0C05},
    {1'b0, 32'hFF00_0002},
    {1'b1, 32'h00FF_FC01},
    {1'b0, 32'h0301_0BFF},
    {1'b1, 32'h0001_0003},
    {1'b0, 32'h0001_0003}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_stb = 1'b0;
  logic        passive_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        vsync, vactive, frame_start;
  logic [9:0]  line_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_vframe_gen dut (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .passive_mode(passive_mode),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .vsync(vsync), .vactive(vactive), .frame_start(frame_start), .line_idx(line_idx)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic strobe();
    @(negedge clk) line_stb = 1'b1;
    @(negedge clk) line_stb = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic chk_idle_line(input string req);
    chk(req, "vactive", int'(vactive), 0);
    chk(req, "line_idx", int'(line_idx), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int p_bp, p_fp, p_sw, p_ln;
    p_bp = 0; p_fp = 0; p_sw = 0; p_ln = 0;

    repeat (3) idle();
    // R2: state while reset is held
    chk("R2", "vsync in reset", int'(vsync), 1);
    chk("R2", "vactive in reset", int'(vactive), 0);
    rst_n = 1'b1;
    idle(); idle();
    chk("R2", "vsync", int'(vsync), 1);
    chk("R2", "vactive", int'(vactive), 0);
    chk("R2", "line_idx", int'(line_idx), 0);
    chk("R2", "frame_start", int'(frame_start), 0);
    chk("R1", "reset readback", int'(cfg_rdata), 0);

    // Zero setting: 1 sync line, no back porch, 1 active line
    strobe();
    chk("R4", "active after skipped back porch", int'(vactive), 1);
    chk("R8", "frame_start pulse", int'(frame_start), 1);
    chk("R5", "vsync off in active", int'(vsync), 0);
    idle();
    chk("R8", "frame_start one cycle", int'(frame_start), 0);

    // R9: no strobe, no change
    repeat (10) idle();
    chk("R9", "vactive held", int'(vactive), 1);
    chk("R9", "line_idx held", int'(line_idx), 0);
    chk("R9", "vsync held", int'(vsync), 0);

    for (int v = 0; v < NVEC; v++) begin
      int n_bp, n_fp, n_sw, n_ln, n_pas;
      n_pas = int'(VEC[v][32]);
      n_bp  = int'(VEC[v][31:24]);
      n_fp  = int'(VEC[v][23:16]);
      n_sw  = int'(VEC[v][15:10]);
      n_ln  = int'(VEC[v][9:0]);

      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = VEC[v][31:0]; passive_mode = VEC[v][32];
      @(negedge clk);
      cfg_we = 1'b0;
      chk("R1", "readback", int'(cfg_rdata), int'(VEC[v][31:0]));

      // R10: remainder of the running frame keeps the previous setting
      for (int k = 1; k <= p_ln; k++) begin
        strobe();
        chk("R7", "vactive old frame", int'(vactive), 1);
        chk("R10", "line_idx old frame", int'(line_idx), k);
        chk("R5", "vsync in active", int'(vsync), 0);
      end
      for (int k = 0; k < p_fp; k++) begin
        strobe();
        chk_idle_line("R10");
        chk("R3", "vsync in front porch", int'(vsync), 0);
      end
      for (int k = 0; k <= n_sw; k++) begin
        strobe();
        chk_idle_line("R3");
        if (n_pas != 0) chk("R6", "vsync passive", int'(vsync), 0);
        else            chk("R5", "vsync active mode", int'(vsync), 1);
      end
      for (int k = 0; k < n_bp; k++) begin
        strobe();
        chk_idle_line("R3");
        chk("R3", "vsync in back porch", int'(vsync), 0);
      end
      strobe();
      chk((n_bp == 0) ? "R4" : "R3", "first active line", int'(vactive), 1);
      chk("R7", "line_idx first", int'(line_idx), 0);
      chk("R8", "frame_start", int'(frame_start), 1);
      chk("R6", "vsync at frame start", int'(vsync), 0);
      idle();
      chk("R8", "frame_start cleared", int'(frame_start), 0);

      p_bp = n_bp; p_fp = n_fp; p_sw = n_sw; p_ln = n_ln;
    end

    // Reset in mid-run returns to the reset state
    @(negedge clk) rst_n = 1'b0;
    idle();
    @(negedge clk) rst_n = 1'b1;
    idle();
    chk("R2", "vsync after rerun reset", int'(vsync), 1);
    chk("R2", "vactive after rerun reset", int'(vactive), 0);
    chk("R1", "register cleared", int'(cfg_rdata), 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule